// File: doc/BRIEF.md
# I2C Master Status and Interrupt Unit

This block gathers the signals around an I2C master into one 16-bit read-only status word and one interrupt request. It takes one-cycle event pulses from the master engine (transfer finished, NACK after the address, NACK after a data byte, arbitration lost) and the engine's busy level. It also takes the fill counts of the transmit and receive FIFOs, the receive-FIFO push strobe, and the raw SCL and SDA lines. The bit-level master sequencer and the FIFO storage sit outside and appear here only as inputs.

Event bits are sticky and clear when the status word is read. Level bits are sampled again every cycle. A bus monitor synchronises SCL and SDA and recognises START and STOP conditions. From these it keeps a bus-busy flag that covers traffic from any master on the bus. A five-bit enable mask selects which sources drive the registered, active-high interrupt output.

Top module: `i2c_mstat_unit`

## Requirements
- R1: Status bit 10 (bus busy) becomes 1 after SDA falls while SCL is high (START). It becomes 0 after SDA rises while SCL is high (STOP). SDA changes while SCL is low leave it unchanged. Each line passes two synchronising flops before detection, so the bit changes three clock edges after the line change.
- R2: Status bit 9 (receive overflow) is set on the edge where `rx_push` is high while `rx_count` equals RX_DEPTH. A push below full does not set it.
- R3: Status bit 8 (transfer done) is set on the edge after a cycle with `ev_done` high.
- R4: Status bit 4 (address NACK) is set by `ev_addr_nack`, and status bit 7 (data NACK) is set by `ev_data_nack`. Each bit is set only by its own event.
- R5: Status bit 5 (arbitration lost) is set by `ev_arb_lost`.
- R6: Status bits 4, 5, 7, 8 and 9 hold until a cycle with `stat_rd` high, which clears them on the next edge. An event in the same cycle as the read leaves its bit set.
- R7: Status bit 6 (engine busy) equals `eng_busy` from the previous cycle. It is independent of bus busy.
- R8: Status bit 2 (transmit request) is 1 one edge after a cycle in which `addr_wr_sent` is high and `tx_count` is 0 or 1. Otherwise it is 0.
- R9: Status bit 3 (receive request) is 1 one edge after a cycle in which `rx_count` is nonzero.
- R10: Status bits 1:0 encode the previous cycle's `tx_count`: 00 for empty, 01 when partly filled, 11 when equal to TX_DEPTH. Bits 15:11 are always 0.
- R11: `irq` is registered. It is the OR of the status bits sampled on its edge, each gated by its enable: `irq_en[0]` for done, `irq_en[1]` for either NACK bit, `irq_en[2]` for arbitration lost, `irq_en[3]` for receive request, and `irq_en[4]` for transmit request. A clear mask gives `irq` = 0 on the next edge.
- R12: While `rst` is high and directly after reset, the status word is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| ev_done | input | 1 | Transfer finished pulse |
| ev_addr_nack | input | 1 | NACK after address pulse |
| ev_data_nack | input | 1 | NACK after data write pulse |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| eng_busy | input | 1 | Master engine processing a transaction |
| addr_wr_sent | input | 1 | Current transaction began with address plus write |
| tx_count | input | $clog2(TX_DEPTH+1) | Transmit FIFO fill count |
| rx_count | input | $clog2(RX_DEPTH+1) | Receive FIFO fill count |
| rx_push | input | 1 | Byte written into receive FIFO |
| stat_rd | input | 1 | Status word read strobe |
| irq_en | input | 5 | Interrupt enables (done, NACK, arb, rx req, tx req) |
| stat_word | output | 16 | Status word |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the unit with TX_DEPTH = 2, RX_DEPTH = 4 and two synchroniser stages. The small depths mean that random fill counts often reach the full value. The transmit-request threshold at one byte and the full code 11 are therefore hit many times. Overflow pushes into a four-entry receive FIFO are frequent, as are reads that coincide with events. The two-stage synchroniser keeps the three-edge START/STOP latency short enough for the directed bus sequences.

// File: rtl/i2c_mstat_pkg.sv
package i2c_mstat_pkg;
  localparam int STAT_W = 16;

  // status word bit positions
  localparam int B_BUS   = 10;
  localparam int B_OVF   = 9;
  localparam int B_DONE  = 8;
  localparam int B_DNACK = 7;
  localparam int B_EBUSY = 6;
  localparam int B_ARB   = 5;
  localparam int B_ANACK = 4;
  localparam int B_RXQ   = 3;
  localparam int B_TXQ   = 2;

  // sticky event vector indices
  localparam int N_EVT   = 5;
  localparam int EV_DONE = 0;
  localparam int EV_ANAK = 1;
  localparam int EV_DNAK = 2;
  localparam int EV_ARB  = 3;
  localparam int EV_OVF  = 4;

  // interrupt enable indices
  localparam int N_EN    = 5;
  localparam int EN_DONE = 0;
  localparam int EN_NACK = 1;
  localparam int EN_ARB  = 2;
  localparam int EN_RXQ  = 3;
  localparam int EN_TXQ  = 4;

  typedef struct packed {
    logic       tx_req;
    logic       rx_req;
    logic       eng_busy;
    logic [1:0] tx_code;
  } lvl_t;
endpackage

// File: rtl/bus_cond_mon.sv
module bus_cond_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic bus_busy
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_s, sda_s, scl_p, sda_p;
  logic start_det, stop_det;
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_in};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_in};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_s = scl_q[SYNC_STAGES-1];
  assign sda_s = sda_q[SYNC_STAGES-1];

  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  always_ff @(posedge clk) begin
    if (rst)            bus_busy <= 1'b0;
    else if (start_det) bus_busy <= 1'b1;
    else if (stop_det)  bus_busy <= 1'b0;
  end

  always_ff @(posedge clk) past_ok <= !rst;

  assert_busy_on_start_R1: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(start_det)) |-> bus_busy);
  assert_idle_on_stop_R1: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(stop_det)) |-> !bus_busy);
  assert_busy_steady_R1: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(start_det) && !$past(stop_det)) |-> $stable(bus_busy));
endmodule

// File: rtl/evt_latch.sv
module evt_latch #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (clr ? '0 : q) | set;
  end

  always_ff @(posedge clk) past_ok <= !rst;

  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(clr)) |-> (($past(q) & ~q) == '0));
  assert_event_wins_R6: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((q & $past(set)) == $past(set)));
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(clr)) |-> (q == $past(set)));
endmodule

// File: rtl/lvl_track.sv
module lvl_track
  import i2c_mstat_pkg::*;
#(
  parameter int TX_DEPTH = 2,
  parameter int RX_DEPTH = 4,
  localparam int TXC_W = $clog2(TX_DEPTH + 1),
  localparam int RXC_W = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TXC_W-1:0] tx_count,
  input  logic [RXC_W-1:0] rx_count,
  input  logic             addr_wr_sent,
  input  logic             eng_busy,
  output logic             rx_full,
  output lvl_t             lvl
);
  lvl_t lvl_d;
  logic past_ok;

  assign rx_full = (rx_count == RXC_W'(RX_DEPTH));

  always_comb begin
    lvl_d.eng_busy = eng_busy;
    lvl_d.rx_req   = (rx_count != '0);
    lvl_d.tx_req   = addr_wr_sent && (tx_count <= TXC_W'(1));
    if (tx_count == '0)                      lvl_d.tx_code = 2'b00;
    else if (tx_count >= TXC_W'(TX_DEPTH))   lvl_d.tx_code = 2'b11;
    else                                     lvl_d.tx_code = 2'b01;
  end

  always_ff @(posedge clk) begin
    if (rst) lvl <= '0;
    else     lvl <= lvl_d;
  end

  always_ff @(posedge clk) past_ok <= !rst;

  assert_txcode_full_R10: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(tx_count) == TXC_W'(TX_DEPTH)) |-> (lvl.tx_code == 2'b11));
  assert_txreq_needs_addr_R8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(addr_wr_sent)) |-> !lvl.tx_req);
  assert_rxreq_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(rx_count) == '0) |-> !lvl.rx_req);
endmodule

// File: rtl/irq_combine.sv
module irq_combine
  import i2c_mstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat,
  input  logic [N_EN-1:0]   en,
  output logic              irq
);
  logic [N_EN-1:0] src;
  logic past_ok;

  always_comb begin
    src          = '0;
    src[EN_DONE] = stat[B_DONE];
    src[EN_NACK] = stat[B_ANACK] | stat[B_DNACK];
    src[EN_ARB]  = stat[B_ARB];
    src[EN_RXQ]  = stat[B_RXQ];
    src[EN_TXQ]  = stat[B_TXQ];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(src & en);
  end

  always_ff @(posedge clk) past_ok <= !rst;

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(en) == '0) |-> !irq);
  assert_irq_done_R11: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(en[EN_DONE]) && $past(stat[B_DONE])) |-> irq);
endmodule

// File: rtl/i2c_mstat_unit.sv
module i2c_mstat_unit
  import i2c_mstat_pkg::*;
#(
  parameter int TX_DEPTH    = 2,
  parameter int RX_DEPTH    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int TXC_W = $clog2(TX_DEPTH + 1),
  localparam int RXC_W = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              ev_done,
  input  logic              ev_addr_nack,
  input  logic              ev_data_nack,
  input  logic              ev_arb_lost,
  input  logic              eng_busy,
  input  logic              addr_wr_sent,
  input  logic [TXC_W-1:0]  tx_count,
  input  logic [RXC_W-1:0]  rx_count,
  input  logic              rx_push,
  input  logic              stat_rd,
  input  logic [N_EN-1:0]   irq_en,
  output logic [STAT_W-1:0] stat_word,
  output logic              irq
);
  logic             bus_busy;
  logic             rx_full;
  lvl_t             lvl;
  logic [N_EVT-1:0] evt_set, evt_q;
  logic             past_ok;

  bus_cond_mon #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .bus_busy(bus_busy)
  );

  lvl_track #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_lvl (
    .clk(clk), .rst(rst), .tx_count(tx_count), .rx_count(rx_count),
    .addr_wr_sent(addr_wr_sent), .eng_busy(eng_busy), .rx_full(rx_full), .lvl(lvl)
  );

  always_comb begin
    evt_set          = '0;
    evt_set[EV_DONE] = ev_done;
    evt_set[EV_ANAK] = ev_addr_nack;
    evt_set[EV_DNAK] = ev_data_nack;
    evt_set[EV_ARB]  = ev_arb_lost;
    evt_set[EV_OVF]  = rx_push & rx_full;
  end

  evt_latch #(.N(N_EVT)) u_evt (
    .clk(clk), .rst(rst), .set(evt_set), .clr(stat_rd), .q(evt_q)
  );

  always_comb begin
    stat_word          = '0;
    stat_word[B_BUS]   = bus_busy;
    stat_word[B_OVF]   = evt_q[EV_OVF];
    stat_word[B_DONE]  = evt_q[EV_DONE];
    stat_word[B_DNACK] = evt_q[EV_DNAK];
    stat_word[B_EBUSY] = lvl.eng_busy;
    stat_word[B_ARB]   = evt_q[EV_ARB];
    stat_word[B_ANACK] = evt_q[EV_ANAK];
    stat_word[B_RXQ]   = lvl.rx_req;
    stat_word[B_TXQ]   = lvl.tx_req;
    stat_word[1:0]     = lvl.tx_code;
  end

  irq_combine u_irq (
    .clk(clk), .rst(rst), .stat(stat_word), .en(irq_en), .irq(irq)
  );

  always_ff @(posedge clk) past_ok <= !rst;

  assert_overflow_set_R2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(rx_push) && $past(rx_count) == RXC_W'(RX_DEPTH)) |-> stat_word[B_OVF]);
  assert_done_set_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(ev_done)) |-> stat_word[B_DONE]);
  assert_nack_split_R4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(stat_rd) && !$past(ev_addr_nack)) |-> !stat_word[B_ANACK]);
  assert_arb_set_R5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(ev_arb_lost)) |-> stat_word[B_ARB]);
  assert_engbusy_R7: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (stat_word[B_EBUSY] == $past(eng_busy)));
  assert_upper_zero_R10: assert property (@(posedge clk)
    stat_word[STAT_W-1:11] == '0);
endmodule

// File: tb/i2c_mstat_unit_tb_top.sv
module i2c_mstat_unit_tb_top;
  localparam int TXD = 2;
  localparam int RXD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic ev_done = 0, ev_addr_nack = 0, ev_data_nack = 0, ev_arb_lost = 0;
  logic eng_busy = 0, addr_wr_sent = 0, rx_push = 0, stat_rd = 0;
  logic [1:0] tx_count = '0;
  logic [2:0] rx_count = '0;
  logic [4:0] irq_en = '0;
  logic [15:0] stat_word;
  logic irq;

  int n_chk = 0, n_bad = 0;

  // expected model
  logic [4:0] x_evt = '0;   // done, anack, dnack, arb, ovf
  logic x_bus = 0, x_ebusy = 0, x_txq = 0, x_rxq = 0, x_irq = 0;
  logic [1:0] x_code = '0;

  always #5 clk = ~clk;

  i2c_mstat_unit #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .ev_done(ev_done), .ev_addr_nack(ev_addr_nack), .ev_data_nack(ev_data_nack),
    .ev_arb_lost(ev_arb_lost), .eng_busy(eng_busy), .addr_wr_sent(addr_wr_sent),
    .tx_count(tx_count), .rx_count(rx_count), .rx_push(rx_push), .stat_rd(stat_rd),
    .irq_en(irq_en), .stat_word(stat_word), .irq(irq)
  );

  function automatic logic [1:0] fcode(int c);
    if (c == 0) return 2'b00;
    if (c >= TXD) return 2'b11;
    return 2'b01;
  endfunction

  function automatic logic [4:0] irq_src();
    return {x_txq, x_rxq, x_evt[3], x_evt[1] | x_evt[2], x_evt[0]};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk({"R1 bus busy ", tag}, 16'(stat_word[10]), 16'(x_bus));
    chk({"R2 overflow ", tag}, 16'(stat_word[9]), 16'(x_evt[4]));
    chk({"R3 done ", tag}, 16'(stat_word[8]), 16'(x_evt[0]));
    chk({"R4 nacks ", tag}, 16'({stat_word[7], stat_word[4]}), 16'({x_evt[2], x_evt[1]}));
    chk({"R5 arb ", tag}, 16'(stat_word[5]), 16'(x_evt[3]));
    chk({"R7 eng busy ", tag}, 16'(stat_word[6]), 16'(x_ebusy));
    chk({"R8 tx req ", tag}, 16'(stat_word[2]), 16'(x_txq));
    chk({"R9 rx req ", tag}, 16'(stat_word[3]), 16'(x_rxq));
    chk({"R10 code ", tag}, {stat_word[15:11], stat_word[1:0]}, {5'b0, x_code});
    chk({"R11 irq ", tag}, 16'(irq), 16'(x_irq));
  endtask

  // called at a negedge: drive, model one edge, check at next negedge
  task automatic step(input logic d, an, dn, arb, eb, aw, push, rd,
                      input int txc, input int rxc, input logic [4:0] en, input string tag);
    ev_done = d; ev_addr_nack = an; ev_data_nack = dn; ev_arb_lost = arb;
    eng_busy = eb; addr_wr_sent = aw; rx_push = push; stat_rd = rd;
    tx_count = 2'(txc); rx_count = 3'(rxc); irq_en = en;
    x_irq  = |(irq_src() & en);
    x_evt  = (rd ? 5'b0 : x_evt) | {push && (rxc == RXD), arb, dn, an, d};
    x_ebusy = eb;
    x_txq  = aw && (txc <= 1);
    x_rxq  = (rxc != 0);
    x_code = fcode(txc);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0,0,0,0,0,0,0,0,0,0,5'b0,"idle");
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R12 status in reset", stat_word, 16'h0000);
    chk("R12 irq in reset", 16'(irq), 16'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 status after reset", stat_word, 16'h0000);
    chk("R12 irq after reset", 16'(irq), 16'h0);

    // R1: START, SDA wiggle with SCL low, STOP
    sda_in = 1'b0;
    repeat (4) @(negedge clk);
    x_bus = 1'b1;
    idle(1);
    scl_in = 1'b0; @(negedge clk);
    sda_in = 1'b1; @(negedge clk);
    sda_in = 1'b0; @(negedge clk);
    scl_in = 1'b1;
    repeat (4) @(negedge clk);
    idle(1);   // bus must still be busy (R1)
    sda_in = 1'b1;
    repeat (4) @(negedge clk);
    x_bus = 1'b0;
    idle(1);

    // R6: read and event in one cycle, then plain read
    step(1,0,0,0,0,0,0,0,0,0,5'b00001,"R6 set");
    step(1,0,0,0,0,0,0,1,0,0,5'b00001,"R6 read with event");
    step(0,0,0,0,0,0,0,1,0,0,5'b00001,"R6 read clears");
    idle(1);

    // R4: separate NACK bits, shared enable
    step(0,1,0,0,0,0,0,0,0,0,5'b00010,"R4 addr nack");
    step(0,0,0,0,0,0,0,0,0,0,5'b00010,"R4 irq from addr nack");
    step(0,0,0,0,0,0,0,1,0,0,5'b00010,"R4 clear");
    step(0,0,1,0,0,0,0,0,0,0,5'b00010,"R4 data nack");
    step(0,0,0,0,0,0,0,1,0,0,5'b00010,"R4 clear2");

    // R2: push below full and at full
    step(0,0,0,0,0,0,1,0,0,RXD-1,5'b0,"R2 push below full");
    step(0,0,0,0,0,0,1,0,0,RXD,5'b0,"R2 push at full");
    step(0,0,0,0,0,0,0,0,0,RXD,5'b0,"R2 hold");

    // R8 / R10 corners
    step(0,0,0,0,0,1,0,0,2,0,5'b10000,"R8 full no req");
    step(0,0,0,0,0,1,0,0,1,0,5'b10000,"R8 one byte");
    step(0,0,0,0,0,0,0,0,0,0,5'b10000,"R8 no addr");
    step(0,0,0,0,0,1,0,1,0,0,5'b10000,"R8 empty");
    idle(2);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 8) == 0, ($urandom % 10) == 0, ($urandom % 10) == 0,
           ($urandom % 12) == 0, 1'($urandom), 1'($urandom),
           ($urandom % 3) == 0, ($urandom % 6) == 0,
           int'($urandom % (TXD + 1)), int'($urandom % (RXD + 1)),
           5'($urandom), "random");
    end

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule